// File: doc/BRIEF.md
# Trap Entry Control Unit

This unit takes a processor trap, which is either a synchronous exception or an asynchronous interrupt, and performs the register side of entering the handler. In the cycle the request is presented it decides whether supervisor or machine level receives the trap, and it drives the handler address as a one-cycle redirect. At the next clock edge it writes the chosen level's cause, exception PC and trap-value registers, pushes the interrupt-enable and privilege stack of that level, and moves the hart to the new privilege.

The surrounding core feeds the unit the live privilege, the status bits, both delegation masks and both trap-vector registers. It reads back the registered trap state, which holds its value between traps. An environment call arrives with the user-level code and is renumbered here from the privilege it was raised at. Interrupts alone may use the vectored handler table.

Privilege encoding: user 0, supervisor 1, machine 3. Cause codes: instruction misaligned 0, instruction access fault 1, breakpoint 3, load misaligned 4, load access fault 5, store misaligned 6, store access fault 7, environment call from user 8, from supervisor 9, from machine 11, instruction/load/store page fault 12/13/15.

Top module: `trap_entry_unit`

## Requirements
- R1: A trap is routed to supervisor level only when the current privilege is user or supervisor and the delegation bit indexed by the final cause code is 1. Any other trap, including every trap taken while in machine mode, is routed to machine level.
- R2: Interrupts look up the interrupt delegation mask (`irq_deleg`). Exceptions look up the exception delegation mask (`exc_deleg`). The other mask has no effect on the routing.
- R3: On entry to the target level, its previous-enable bit takes that level's current enable bit, its previous-privilege field takes the current privilege, and its enable bit becomes 0. The supervisor previous-privilege field is 1 bit (1 means supervisor, 0 means user). The status fields of the other level are loaded from the inputs unchanged.
- R4: The cause register of the target level holds the final code, zero-extended, with bit XLEN-1 set to 1 for an interrupt and 0 for an exception.
- R5: The redirect PC is the target level's vector with bits 1:0 cleared. 4 × code is added only when the trap is an interrupt and the vector's bits 1:0 equal 1. The values 0, 2 and 3 in bits 1:0 all give the base address.
- R6: The trap value of the target level receives the fault address for exception codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It receives 0 for every other exception and for every interrupt.
- R7: An exception with code 8 becomes code 9 when raised from supervisor and code 11 when raised from machine, and stays 8 from user. The renamed code is used both for delegation and for the cause register. An interrupt with code 8 is not renamed.
- R8: The target level's exception PC receives the trapping PC, and the output privilege becomes the target level. The cause, exception PC and trap value of the other level keep their values.
- R9: All trap registers update on the clock edge that samples the trap request. The redirect valid flag and the redirect PC are driven combinationally in that same cycle. Without a request, every registered output holds and the redirect valid flag is 0.
- R10: While reset is asserted, all cause, exception PC, trap value and status outputs are 0 and the output privilege is machine (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap request for this cycle |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | CAUSE_W | Raw cause code |
| fault_addr | input | XLEN | Faulting address for the trap value |
| trap_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| in_mie | input | 1 | Current machine interrupt enable |
| in_mpie | input | 1 | Current machine previous enable |
| in_mpp | input | 2 | Current machine previous privilege |
| in_sie | input | 1 | Current supervisor interrupt enable |
| in_spie | input | 1 | Current supervisor previous enable |
| in_spp | input | 1 | Current supervisor previous privilege |
| m_vec | input | XLEN | Machine trap vector (bits 1:0 = mode) |
| s_vec | input | XLEN | Supervisor trap vector (bits 1:0 = mode) |
| m_cause | output | XLEN | Machine cause register |
| m_epc | output | XLEN | Machine exception PC |
| m_tval | output | XLEN | Machine trap value |
| s_cause | output | XLEN | Supervisor cause register |
| s_epc | output | XLEN | Supervisor exception PC |
| s_tval | output | XLEN | Supervisor trap value |
| out_mie | output | 1 | Machine interrupt enable after entry |
| out_mpie | output | 1 | Machine previous enable after entry |
| out_mpp | output | 2 | Machine previous privilege after entry |
| out_sie | output | 1 | Supervisor interrupt enable after entry |
| out_spie | output | 1 | Supervisor previous enable after entry |
| out_spp | output | 1 | Supervisor previous privilege after entry |
| new_priv | output | 2 | Privilege after the trap |
| redirect_valid | output | 1 | Redirect PC is valid this cycle |
| redirect_pc | output | XLEN | Handler address |

## Verification
The vector table sets the same cause against opposite masks. Putting the code in the wrong mask tells the interrupt lookup apart from the exception lookup. A delegated code raised from machine mode exposes a missing privilege gate. Environment calls from each privilege are paired with masks that delegate only the raw code or only the renamed code, so renaming after delegation gives the wrong target. Interrupts and exceptions are sent through vectors in each of the four mode values, which separates vectored from direct dispatch. Breakpoint and interrupt entries check that the trap value is cleared. A back-to-back stream of requests and a quiet window with scrambled inputs show that state changes only on a sampled request.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  localparam int CODE_ENV_USER  = 8;
  localparam int CODE_ENV_SUPER = 9;
  localparam int CODE_ENV_MACH  = 11;

  typedef struct packed {
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
    logic       sie;
    logic       spie;
    logic       spp;
  } stat_t;

  // Stack the enable/privilege bits of whichever level takes the trap.
  function automatic stat_t push_status(stat_t cur, logic [1:0] priv, logic to_super);
    stat_t nxt;
    nxt = cur;
    if (to_super) begin
      nxt.spie = cur.sie;
      nxt.spp  = (priv == PRIV_S);
      nxt.sie  = 1'b0;
    end else begin
      nxt.mpie = cur.mie;
      nxt.mpp  = priv;
      nxt.mie  = 1'b0;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/trap_cause_map.sv
module trap_cause_map
  import trap_entry_pkg::*;
#(
  parameter int CAUSE_W = 5
) (
  input  logic               irq,
  input  logic [CAUSE_W-1:0] code,
  input  logic [1:0]         priv,
  output logic [CAUSE_W-1:0] final_code,
  output logic               keeps_addr
);

  localparam logic [CAUSE_W-1:0] ENV_U = CAUSE_W'(CODE_ENV_USER);
  localparam logic [CAUSE_W-1:0] ENV_S = CAUSE_W'(CODE_ENV_SUPER);
  localparam logic [CAUSE_W-1:0] ENV_M = CAUSE_W'(CODE_ENV_MACH);

  always_comb begin
    final_code = code;
    if (!irq && code == ENV_U) begin
      case (priv)
        PRIV_S:  final_code = ENV_S;
        PRIV_M:  final_code = ENV_M;
        default: final_code = ENV_U;
      endcase
    end
  end

  always_comb begin
    keeps_addr = 1'b0;
    if (!irq) begin
      case (int'(code))
        0, 1, 4, 5, 6, 7, 12, 13, 15: keeps_addr = 1'b1;
        default:                      keeps_addr = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/trap_delegate.sv
module trap_delegate
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               irq,
  input  logic [CAUSE_W-1:0] code,
  input  logic [1:0]         priv,
  input  logic [XLEN-1:0]    exc_mask,
  input  logic [XLEN-1:0]    irq_mask,
  output logic               to_super
);

  logic [XLEN-1:0] mask_sel;
  logic [XLEN-1:0] shifted;
  logic            low_priv;

  assign mask_sel = irq ? irq_mask : exc_mask;
  assign shifted  = mask_sel >> code;
  assign low_priv = (priv == PRIV_U) || (priv == PRIV_S);
  assign to_super = low_priv && shifted[0];

endmodule

// File: rtl/trap_vector_pc.sv
module trap_vector_pc #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               irq,
  input  logic [CAUSE_W-1:0] code,
  input  logic [XLEN-1:0]    tvec,
  output logic [XLEN-1:0]    pc
);

  function automatic logic [XLEN-1:0] handler_addr(logic [XLEN-1:0] vec,
                                                   logic is_irq,
                                                   logic [CAUSE_W-1:0] c);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;
    base = {vec[XLEN-1:2], 2'b00};
    offs = (is_irq && vec[1:0] == 2'b01) ? (XLEN'(c) << 2) : '0;
    return base + offs;
  endfunction

  assign pc = handler_addr(tvec, irq, code);

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req,
  input  logic               trap_is_irq,
  input  logic [CAUSE_W-1:0] trap_code,
  input  logic [XLEN-1:0]    fault_addr,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [1:0]         cur_priv,
  input  logic [XLEN-1:0]    exc_deleg,
  input  logic [XLEN-1:0]    irq_deleg,
  input  logic               in_mie,
  input  logic               in_mpie,
  input  logic [1:0]         in_mpp,
  input  logic               in_sie,
  input  logic               in_spie,
  input  logic               in_spp,
  input  logic [XLEN-1:0]    m_vec,
  input  logic [XLEN-1:0]    s_vec,
  output logic [XLEN-1:0]    m_cause,
  output logic [XLEN-1:0]    m_epc,
  output logic [XLEN-1:0]    m_tval,
  output logic [XLEN-1:0]    s_cause,
  output logic [XLEN-1:0]    s_epc,
  output logic [XLEN-1:0]    s_tval,
  output logic               out_mie,
  output logic               out_mpie,
  output logic [1:0]         out_mpp,
  output logic               out_sie,
  output logic               out_spie,
  output logic               out_spp,
  output logic [1:0]         new_priv,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc
);

  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  // Named internal events.
  logic [CAUSE_W-1:0] final_code;
  logic               keeps_addr;
  logic               to_super;
  logic [XLEN-1:0]    sel_vec;
  logic [XLEN-1:0]    cause_word;
  logic [XLEN-1:0]    tval_word;
  stat_t              stat_in;
  stat_t              stat_next;
  stat_t              stat_q;

  trap_cause_map #(.CAUSE_W(CAUSE_W)) u_map (
    .irq        (trap_is_irq),
    .code       (trap_code),
    .priv       (cur_priv),
    .final_code (final_code),
    .keeps_addr (keeps_addr)
  );

  trap_delegate #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_deleg (
    .irq      (trap_is_irq),
    .code     (final_code),
    .priv     (cur_priv),
    .exc_mask (exc_deleg),
    .irq_mask (irq_deleg),
    .to_super (to_super)
  );

  assign sel_vec = to_super ? s_vec : m_vec;

  trap_vector_pc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .irq  (trap_is_irq),
    .code (final_code),
    .tvec (sel_vec),
    .pc   (redirect_pc)
  );

  assign redirect_valid = trap_req;
  assign cause_word     = {trap_is_irq, {PAD_W{1'b0}}, final_code};
  assign tval_word      = keeps_addr ? fault_addr : '0;

  assign stat_in   = '{mie: in_mie, mpie: in_mpie, mpp: in_mpp,
                       sie: in_sie, spie: in_spie, spp: in_spp};
  assign stat_next = push_status(stat_in, cur_priv, to_super);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause  <= '0;
      m_epc    <= '0;
      m_tval   <= '0;
      s_cause  <= '0;
      s_epc    <= '0;
      s_tval   <= '0;
      stat_q   <= '0;
      new_priv <= PRIV_M;
    end else if (trap_req) begin
      stat_q <= stat_next;
      if (to_super) begin
        s_cause  <= cause_word;
        s_epc    <= trap_pc;
        s_tval   <= tval_word;
        new_priv <= PRIV_S;
      end else begin
        m_cause  <= cause_word;
        m_epc    <= trap_pc;
        m_tval   <= tval_word;
        new_priv <= PRIV_M;
      end
    end
  end

  assign out_mie  = stat_q.mie;
  assign out_mpie = stat_q.mpie;
  assign out_mpp  = stat_q.mpp;
  assign out_sie  = stat_q.sie;
  assign out_spie = stat_q.spie;
  assign out_spp  = stat_q.spp;

  // Machine-mode traps never go down to supervisor.
  assert_mach_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_priv == PRIV_M) |=> new_priv == PRIV_M);

  assert_ie_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (new_priv == PRIV_M) ? !out_mie : !out_sie);

  assert_irq_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> ((new_priv == PRIV_M) ? m_cause[XLEN-1] : s_cause[XLEN-1])
                 == $past(trap_is_irq));

  assert_exc_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !trap_is_irq) |-> redirect_pc[1:0] == 2'b00);

  assert_irq_tval_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_is_irq) |=> ((new_priv == PRIV_M) ? m_tval : s_tval) == '0);

  assert_epc_loaded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> ((new_priv == PRIV_M) ? m_epc : s_epc) == $past(trap_pc));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |=> $stable(m_cause) && $stable(s_cause) && $stable(m_epc) &&
                  $stable(s_epc) && $stable(new_priv) && $stable(stat_q));

endmodule

// File: tb/trap_entry_unit_bench.sv
`timescale 1ns/1ps
module trap_entry_unit_bench;

  localparam int XLEN = 32;
  localparam int CW   = 5;
  localparam int NV   = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trap_req = 1'b0, trap_is_irq = 1'b0;
  logic [CW-1:0]   trap_code = '0;
  logic [XLEN-1:0] fault_addr = '0, trap_pc = '0, exc_deleg = '0, irq_deleg = '0;
  logic [1:0]      cur_priv = 2'd3;
  logic            in_mie = 0, in_mpie = 0, in_sie = 0, in_spie = 0, in_spp = 0;
  logic [1:0]      in_mpp = 0;
  logic [XLEN-1:0] m_vec = '0, s_vec = '0;
  logic [XLEN-1:0] m_cause, m_epc, m_tval, s_cause, s_epc, s_tval, redirect_pc;
  logic            out_mie, out_mpie, out_sie, out_spie, out_spp, redirect_valid;
  logic [1:0]      out_mpp, new_priv;

  always #4 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CW)) u_trap_entry_unit (
    .clk, .rst_n, .trap_req, .trap_is_irq, .trap_code, .fault_addr, .trap_pc,
    .cur_priv, .exc_deleg, .irq_deleg, .in_mie, .in_mpie, .in_mpp, .in_sie,
    .in_spie, .in_spp, .m_vec, .s_vec, .m_cause, .m_epc, .m_tval, .s_cause,
    .s_epc, .s_tval, .out_mie, .out_mpie, .out_mpp, .out_sie, .out_spie,
    .out_spp, .new_priv, .redirect_valid, .redirect_pc
  );

  // {irq, code, priv, irq_deleg[15:0], exc_deleg[15:0], vec_mode, to_super, final_code}
  localparam logic [47:0] VT [NV] = '{
    {1'b0, 5'd2,  2'd0, 16'h0000, 16'h0004, 2'd1, 1'b1, 5'd2 },
    {1'b0, 5'd2,  2'd0, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 5'd2 },
    {1'b0, 5'd2,  2'd3, 16'h0000, 16'h0004, 2'd0, 1'b0, 5'd2 },
    {1'b0, 5'd8,  2'd0, 16'h0000, 16'h0100, 2'd1, 1'b1, 5'd8 },
    {1'b0, 5'd8,  2'd1, 16'h0000, 16'h0200, 2'd0, 1'b1, 5'd9 },
    {1'b0, 5'd8,  2'd1, 16'h0000, 16'h0100, 2'd0, 1'b0, 5'd9 },
    {1'b0, 5'd8,  2'd3, 16'hFFFF, 16'hFFFF, 2'd1, 1'b0, 5'd11},
    {1'b1, 5'd5,  2'd1, 16'h0020, 16'h0000, 2'd1, 1'b1, 5'd5 },
    {1'b1, 5'd5,  2'd1, 16'h0000, 16'h0020, 2'd1, 1'b0, 5'd5 },
    {1'b0, 5'd5,  2'd0, 16'h0020, 16'h0000, 2'd1, 1'b0, 5'd5 },
    {1'b1, 5'd7,  2'd3, 16'h0080, 16'h0000, 2'd1, 1'b0, 5'd7 },
    {1'b1, 5'd7,  2'd0, 16'h0000, 16'h0000, 2'd2, 1'b0, 5'd7 },
    {1'b0, 5'd13, 2'd1, 16'h0000, 16'h2000, 2'd3, 1'b1, 5'd13},
    {1'b0, 5'd3,  2'd0, 16'h0000, 16'h0000, 2'd1, 1'b0, 5'd3 },
    {1'b0, 5'd15, 2'd0, 16'h0000, 16'h8000, 2'd1, 1'b1, 5'd15},
    {1'b1, 5'd8,  2'd1, 16'h0100, 16'h0000, 2'd1, 1'b1, 5'd8 }
  };

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [XLEN-1:0] sh_mc, sh_me, sh_mt, sh_sc, sh_se, sh_st;
  logic [6:0]      sh_stat;
  logic [1:0]      sh_priv;

  function automatic logic [6:0] stat_now();
    return {out_mie, out_mpie, out_mpp, out_sie, out_spie, out_spp};
  endfunction

  task automatic snap();
    sh_mc = m_cause; sh_me = m_epc; sh_mt = m_tval;
    sh_sc = s_cause; sh_se = s_epc; sh_st = s_tval;
    sh_stat = stat_now(); sh_priv = new_priv;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    chk("R10", "m_cause", m_cause, '0);
    chk("R10", "s_epc", s_epc, '0);
    chk("R10", "m_tval", m_tval, '0);
    chk("R10", "status", {25'd0, stat_now()}, '0);
    chk("R10", "priv", {30'd0, new_priv}, 32'd3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "idle valid", {31'd0, redirect_valid}, 32'd0);
    snap();

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      logic [7:0]  b;
      logic        irq, to_s;
      logic [4:0]  code, fcode;
      logic [1:0]  pr, vm;
      logic [XLEN-1:0] vec, exp_pc, exp_tv, exp_cause;
      logic [6:0]  exp_st;
      v = VT[i];
      b = 8'(i * 37 + 5);
      irq = v[47]; code = v[46:42]; pr = v[41:40]; vm = v[7:6];
      to_s = v[5]; fcode = v[4:0];
      trap_req    = 1'b1;
      trap_is_irq = irq;
      trap_code   = code;
      cur_priv    = pr;
      irq_deleg   = {16'h0, v[39:24]};
      exc_deleg   = {16'h0, v[23:8]};
      trap_pc     = 32'h1000_0000 + 32'(i) * 16;
      fault_addr  = 32'hABC0_0000 | 32'(i);
      m_vec       = 32'h8000_0100 | {30'd0, vm};
      s_vec       = 32'h4000_0200 | {30'd0, vm};
      in_mie = b[0]; in_sie = b[1]; in_mpie = b[2]; in_spie = b[3];
      in_mpp = b[5:4]; in_spp = b[6];
      vec = to_s ? s_vec : m_vec;
      exp_pc = (vec & ~32'd3) + ((irq && vm == 2'd1) ? 32'(fcode) * 4 : 32'd0);
      exp_tv = (!irq && code < 16 && ((16'hB0F3 >> code) & 16'd1) != 0) ? fault_addr : '0;
      exp_cause = (irq ? 32'h8000_0000 : 32'h0) + 32'(fcode);
      if (to_s)
        exp_st = {in_mie, in_mpie, in_mpp, 1'b0, in_sie, (pr == 2'd1)};
      else
        exp_st = {1'b0, in_mie, pr, in_sie, in_spie, in_spp};
      #1;
      chk("R9", "redirect valid", {31'd0, redirect_valid}, 32'd1);
      chk("R5", "redirect pc", redirect_pc, exp_pc);
      @(negedge clk);
      chk("R1", "target priv", {30'd0, new_priv}, to_s ? 32'd1 : 32'd3);
      chk("R3", "status", {25'd0, stat_now()}, {25'd0, exp_st});
      if (to_s) begin
        chk("R4", "s_cause", s_cause, exp_cause);
        chk("R8", "s_epc", s_epc, trap_pc);
        chk("R6", "s_tval", s_tval, exp_tv);
        chk("R8", "m_cause kept", m_cause, sh_mc);
        chk("R8", "m_epc kept", m_epc, sh_me);
      end else begin
        chk("R4", "m_cause", m_cause, exp_cause);
        chk("R8", "m_epc", m_epc, trap_pc);
        chk("R6", "m_tval", m_tval, exp_tv);
        chk("R8", "s_cause kept", s_cause, sh_sc);
        chk("R8", "s_epc kept", s_epc, sh_se);
      end
      if (i == 5 || i == 6) chk("R7", "renamed code", (to_s ? s_cause : m_cause), exp_cause);
      if (i == 8 || i == 9) chk("R2", "other mask ignored", {30'd0, new_priv}, 32'd3);
      snap();
    end

    // R9: no request, scrambled inputs: nothing moves
    trap_req = 1'b0; trap_is_irq = 1'b1; trap_code = 5'd3; cur_priv = 2'd0;
    irq_deleg = '1; exc_deleg = '1; trap_pc = 32'hDEAD_BEEF; fault_addr = 32'h1234_5678;
    in_mie = 1; in_sie = 1; in_mpie = 1; in_spie = 1; in_mpp = 2'd1; in_spp = 1;
    #1;
    chk("R9", "valid low", {31'd0, redirect_valid}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R9", "m_cause hold", m_cause, sh_mc);
    chk("R9", "s_cause hold", s_cause, sh_sc);
    chk("R9", "m_epc hold", m_epc, sh_me);
    chk("R9", "s_tval hold", s_tval, sh_st);
    chk("R9", "m_tval hold", m_tval, sh_mt);
    chk("R9", "status hold", {25'd0, stat_now()}, {25'd0, sh_stat});
    chk("R9", "priv hold", {30'd0, new_priv}, {30'd0, sh_priv});

    // R10: reset during operation
    rst_n = 1'b0;
    #1;
    chk("R10", "s_cause after reset", s_cause, '0);
    chk("R10", "priv after reset", {30'd0, new_priv}, 32'd3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule